// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns them into one request line, a vector handshake and a sleep wake-up line. Three core sources have their flags and enables in a main control byte. They are an external interrupt pin, a port-change pin and a timer0 overflow pulse. The same byte holds a global enable and a peripheral-group enable. Five peripheral sources have their own flag byte and enable byte. Every flag is sticky: an event sets it whatever the enable state, and only a software write clears it.

Each peripheral flag is ANDed with its enable, and the results are ORed together. The peripheral-group enable gates that OR. The result then joins the enabled core sources, and the global enable gates the whole tree. The CPU looks at the request only on an instruction-cycle strobe. When it accepts, the block returns a one-cycle vector-taken pulse, presents the fixed vector address and clears the global enable. A return-from-interrupt pulse sets the global enable again. The two external pins are asynchronous. They pass through a synchronizer and a rising-edge detector before they reach their flags.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the main control byte, the peripheral flag byte and the peripheral enable byte are all zero, and `irq_o`, `vec_taken_o` and `wake_o` are low.
- R2: A software write uses `reg_sel_i`: 0 selects the main control byte, 1 the peripheral flags and 2 the peripheral enables; 3 is ignored. The main control byte layout is bit7 global enable, bit6 peripheral-group enable, bit5 timer0 enable, bit4 pin-interrupt enable, bit3 port-change enable, bit2 timer0 flag, bit1 pin-interrupt flag and bit0 port-change flag. Peripheral bit i belongs to `per_evt_i[i]`.
- R3: Each flag sets on its event whatever the state of its enable and of the global enable. It stays set until a software write clears it.
- R4: `irq_o` is high exactly when the global enable is set and at least one of the following holds: a core flag and its enable are both set, or the peripheral-group enable is set together with some peripheral flag and its enable.
- R5: A peripheral source with its flag and enable set raises no request while the peripheral-group enable is clear. Core sources do not depend on that bit.
- R6: A rising level on `ext_int_i` or `port_chg_i` sets its flag on the third clock edge after the input changes. A level that stays high does not set the flag again after software clears it.
- R7: When `cyc_strobe_i` is high while `irq_o` is high, `vec_taken_o` is high for exactly the next cycle. The global enable is cleared on that same edge. `vec_addr_o` always reads 0x0004.
- R8: A `reti_i` pulse sets the global enable on the next edge. If a vector is taken on the same edge, the clear takes precedence.
- R9: No vector is taken unless `cyc_strobe_i` is high.
- R10: If an event and a software write that clears its flag arrive in the same cycle, the flag ends up set.
- R11: `wake_o` follows the same enable tree as `irq_o`, but without the global enable.
- R12: If a flag is still set when `reti_i` re-enables interrupts, `irq_o` rises again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Software write strobe |
| reg_sel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | 8 | Write data |
| main_ctrl_o | output | 8 | Main control byte |
| per_flag_o | output | 5 | Peripheral flags |
| per_en_o | output | 5 | Peripheral enables |
| ext_int_i | input | 1 | Asynchronous external interrupt pin |
| port_chg_i | input | 1 | Asynchronous port-change indication |
| tmr0_ovf_i | input | 1 | Timer0 overflow pulse |
| per_evt_i | input | 5 | Peripheral event pulses |
| cyc_strobe_i | input | 1 | Instruction-cycle boundary strobe from the CPU |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_taken_o | output | 1 | One-cycle pulse when the vector is taken |
| vec_addr_o | output | 13 | Vector address |
| wake_o | output | 1 | Wake-up from sleep |

## Verification
The assertions check on every cycle that a request never appears while the global enable is clear. They also check that a request always implies wake-up, that a vector pulse follows only a strobed request and finds the global enable cleared, that a return sets the enable, and that a peripheral event always leaves its flag set. Only the bench scenarios can show the rest. That covers the exact three-edge synchronizer latency, that a held pin level does not re-trigger, and that peripheral requests are blocked by the group enable. It also covers that an event wins over a clearing write in the same cycle, and that a return with an uncleared flag re-enters the interrupt at once.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_MAIN  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int MAIN_W   = 8;
    localparam int B_GIE    = 7;
    localparam int B_PEIE   = 6;
    localparam int B_T0EN   = 5;
    localparam int B_PINEN  = 4;
    localparam int B_PCHEN  = 3;
    localparam int B_T0FL   = 2;
    localparam int B_PINFL  = 1;
    localparam int B_PCHFL  = 0;
    localparam int N_CORE   = 3;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/irq_gate_tree.sv
module irq_gate_tree #(
    parameter int N_PER  = 5,
    parameter int N_CORE = 3
) (
    input  logic [N_CORE-1:0] core_flag_i,
    input  logic [N_CORE-1:0] core_en_i,
    input  logic [N_PER-1:0]  per_flag_i,
    input  logic [N_PER-1:0]  per_en_i,
    input  logic              peie_i,
    input  logic              gie_i,
    output logic              wake_o,
    output logic              req_o
);
    logic [N_PER-1:0]  per_hit;
    logic [N_CORE-1:0] core_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_PER; gi++) begin : g_per
            assign per_hit[gi] = per_flag_i[gi] & per_en_i[gi];
        end
        for (gi = 0; gi < N_CORE; gi++) begin : g_core
            assign core_hit[gi] = core_flag_i[gi] & core_en_i[gi];
        end
    endgenerate

    assign wake_o = (|core_hit) | (peie_i & (|per_hit));
    assign req_o  = gie_i & wake_o;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_pkg::*;
#(
    parameter int N_PER       = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PC_W        = 13,
    parameter int VEC_ADDR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [MAIN_W-1:0] main_ctrl_o,
    output logic [N_PER-1:0]  per_flag_o,
    output logic [N_PER-1:0]  per_en_o,
    input  logic              ext_int_i,
    input  logic              port_chg_i,
    input  logic              tmr0_ovf_i,
    input  logic [N_PER-1:0]  per_evt_i,
    input  logic              cyc_strobe_i,
    input  logic              reti_i,
    output logic              irq_o,
    output logic              vec_taken_o,
    output logic [PC_W-1:0]   vec_addr_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [N_PER-1:0]  pflag;
        logic [N_PER-1:0]  pen;
        logic              vec_taken;
    } state_t;

    state_t st_d, st_q;
    logic   pin_rise, pch_rise;
    logic   req;
    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_sel_i);

    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_int_i), .rise_o(pin_rise)
    );

    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_pch_sync (
        .clk(clk), .rst_n(rst_n), .async_i(port_chg_i), .rise_o(pch_rise)
    );

    irq_gate_tree #(.N_PER(N_PER), .N_CORE(N_CORE)) u_tree (
        .core_flag_i ({st_q.main[B_T0FL], st_q.main[B_PINFL], st_q.main[B_PCHFL]}),
        .core_en_i   ({st_q.main[B_T0EN], st_q.main[B_PINEN], st_q.main[B_PCHEN]}),
        .per_flag_i  (st_q.pflag),
        .per_en_i    (st_q.pen),
        .peie_i      (st_q.main[B_PEIE]),
        .gie_i       (st_q.main[B_GIE]),
        .wake_o      (wake_o),
        .req_o       (req)
    );

    always_comb begin
        st_d = st_q;
        st_d.vec_taken = 1'b0;

        // software write first
        if (reg_wr_i) begin
            case (sel)
                SEL_MAIN:  st_d.main  = reg_wdata_i[MAIN_W-1:0];
                SEL_PFLAG: st_d.pflag = reg_wdata_i[N_PER-1:0];
                SEL_PEN:   st_d.pen   = reg_wdata_i[N_PER-1:0];
                default:   ;
            endcase
        end

        // events override a clearing write
        st_d.main[B_T0FL]  = st_d.main[B_T0FL]  | tmr0_ovf_i;
        st_d.main[B_PINFL] = st_d.main[B_PINFL] | pin_rise;
        st_d.main[B_PCHFL] = st_d.main[B_PCHFL] | pch_rise;
        st_d.pflag         = st_d.pflag | per_evt_i;

        if (reti_i) st_d.main[B_GIE] = 1'b1;

        // vector acceptance has the last word on the global enable
        if (cyc_strobe_i && req) begin
            st_d.main[B_GIE] = 1'b0;
            st_d.vec_taken   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_ctrl_o = st_q.main;
    assign per_flag_o  = st_q.pflag;
    assign per_en_o    = st_q.pen;
    assign irq_o       = req;
    assign vec_taken_o = st_q.vec_taken;
    assign vec_addr_o  = PC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int N_PER = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       main_ctrl_o,
    input logic [N_PER-1:0] per_flag_o,
    input logic [N_PER-1:0] per_evt_i,
    input logic             cyc_strobe_i,
    input logic             reti_i,
    input logic             irq_o,
    input logic             vec_taken_o,
    input logic             wake_o
);
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> main_ctrl_o[7]); // R4
    AST_REQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o); // R11
    AST_VEC_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_taken_o |-> !main_ctrl_o[7]); // R7
    AST_VEC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_taken_o && $past(rst_n)) |-> $past(cyc_strobe_i && irq_o)); // R9
    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(cyc_strobe_i && irq_o)) |=> main_ctrl_o[7]); // R8
    AST_FLAG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_evt_i) |=> ((per_flag_o & $past(per_evt_i)) == $past(per_evt_i))); // R3
endmodule

bind irq_ctl irq_ctl_chk #(.N_PER(N_PER)) u_chk (
    .clk(clk), .rst_n(rst_n), .main_ctrl_o(main_ctrl_o), .per_flag_o(per_flag_o),
    .per_evt_i(per_evt_i), .cyc_strobe_i(cyc_strobe_i), .reti_i(reti_i),
    .irq_o(irq_o), .vec_taken_o(vec_taken_o), .wake_o(wake_o)
);

// File: tb/irq_ctl_tb.sv
`timescale 1ns/1ps
module irq_ctl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr_i = 0;
    logic [1:0] reg_sel_i = 0;
    logic [7:0] reg_wdata_i = 0;
    logic [7:0] main_ctrl_o;
    logic [4:0] per_flag_o, per_en_o;
    logic       ext_int_i = 0, port_chg_i = 0, tmr0_ovf_i = 0;
    logic [4:0] per_evt_i = 0;
    logic       cyc_strobe_i = 0, reti_i = 0;
    logic       irq_o, vec_taken_o, wake_o;
    logic [12:0] vec_addr_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .main_ctrl_o(main_ctrl_o), .per_flag_o(per_flag_o),
        .per_en_o(per_en_o), .ext_int_i(ext_int_i), .port_chg_i(port_chg_i),
        .tmr0_ovf_i(tmr0_ovf_i), .per_evt_i(per_evt_i), .cyc_strobe_i(cyc_strobe_i),
        .reti_i(reti_i), .irq_o(irq_o), .vec_taken_o(vec_taken_o),
        .vec_addr_o(vec_addr_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 main", main_ctrl_o, 0);
        chk("R1 pflag", per_flag_o, 0);
        chk("R1 pen", per_en_o, 0);
        chk("R1 outs", {irq_o, vec_taken_o, wake_o}, 0);
    endtask

    task automatic t_flags_no_enable();
        do_reset();
        @(negedge clk); per_evt_i = 5'b10101; tmr0_ovf_i = 1;
        @(negedge clk); per_evt_i = 0; tmr0_ovf_i = 0;
        chk("R3 pflag sticky", per_flag_o, 5'b10101);
        chk("R3 t0 flag", main_ctrl_o, 8'h04);
        repeat (3) @(negedge clk);
        chk("R3 still set", per_flag_o, 5'b10101);
        chk("R3 no irq", irq_o, 0);
        wr(2'd1, 8'h00);
        chk("R2 sw clear", per_flag_o, 0);
        wr(2'd3, 8'hFF);
        chk("R2 sel3 ignored", {main_ctrl_o, per_flag_o, per_en_o}, {8'h04, 10'h0});
    endtask

    task automatic t_core_irq();
        do_reset();
        wr(2'd0, 8'h20);            // timer0 enable only
        @(negedge clk); tmr0_ovf_i = 1;
        @(negedge clk); tmr0_ovf_i = 0;
        chk("R11 wake without gie", wake_o, 1);
        chk("R4 no irq without gie", irq_o, 0);
        wr(2'd0, 8'hA4);            // gie + t0 enable + keep flag
        chk("R4 core irq", irq_o, 1);
        wr(2'd0, 8'h80);            // clear flag
        chk("R4 irq drops", {irq_o, wake_o}, 0);
    endtask

    task automatic t_periph_gate();
        do_reset();
        wr(2'd2, 8'h08);            // enable peripheral 3
        wr(2'd0, 8'h80);            // gie, no group enable
        @(negedge clk); per_evt_i = 5'b01000;
        @(negedge clk); per_evt_i = 0;
        chk("R5 blocked by group", {irq_o, wake_o}, 0);
        wr(2'd0, 8'hC0);
        chk("R5 group open", irq_o, 1);
        chk("R2 pen readback", per_en_o, 5'b01000);
    endtask

    task automatic t_sync();
        do_reset();
        @(negedge clk); ext_int_i = 1;
        repeat (2) @(negedge clk);
        chk("R6 not yet", main_ctrl_o[1], 0);
        @(negedge clk);
        chk("R6 third edge", main_ctrl_o[1], 1);
        wr(2'd0, 8'h00);
        repeat (4) @(negedge clk);
        chk("R6 held level no retrigger", main_ctrl_o[1], 0);
        ext_int_i = 0; port_chg_i = 1;
        repeat (3) @(negedge clk);
        chk("R6 port change flag", main_ctrl_o[0], 1);
        port_chg_i = 0;
    endtask

    task automatic t_vector_retake();
        do_reset();
        wr(2'd0, 8'hA0);
        @(negedge clk); tmr0_ovf_i = 1;
        @(negedge clk); tmr0_ovf_i = 0;
        chk("R4 pending", irq_o, 1);
        repeat (2) @(negedge clk);
        chk("R9 no vector w/o strobe", vec_taken_o, 0);
        cyc_strobe_i = 1;
        @(negedge clk); cyc_strobe_i = 0;
        chk("R7 vec pulse", vec_taken_o, 1);
        chk("R7 gie cleared", main_ctrl_o[7], 0);
        chk("R7 vec addr", vec_addr_o, 13'h0004);
        @(negedge clk);
        chk("R7 single pulse", vec_taken_o, 0);
        reti_i = 1;
        @(negedge clk); reti_i = 0;
        chk("R8 gie set", main_ctrl_o[7], 1);
        chk("R12 retake", irq_o, 1);
        reti_i = 1; cyc_strobe_i = 1;
        @(negedge clk); reti_i = 0; cyc_strobe_i = 0;
        chk("R8 vector beats reti", {vec_taken_o, main_ctrl_o[7]}, 2'b10);
    endtask

    task automatic t_set_vs_clear();
        do_reset();
        @(negedge clk); per_evt_i = 5'b00011;
        @(negedge clk); per_evt_i = 0;
        @(negedge clk);
        reg_wr_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 8'h00; per_evt_i = 5'b00001;
        @(negedge clk);
        reg_wr_i = 0; per_evt_i = 0;
        chk("R10 set wins", per_flag_o, 5'b00001);
    endtask

    initial begin
        t_reset();
        t_flags_no_enable();
        t_core_irq();
        t_periph_gate();
        t_sync();
        t_vector_retake();
        t_set_vs_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule